// File: doc/BRIEF.md
# Word-Serial AES-128 Cipher Core

This core encrypts or decrypts one 128-bit block under a 128-bit key using the ten-round AES-128 cipher. A host writes the key and the data block as four 32-bit words each into two load buffers. It then pulses `start` with `decrypt` choosing the direction. When the run ends, the core pulses `done` and holds the result in an output buffer. The host reads that buffer back one 32-bit word at a time by index.

Each run first expands the whole key schedule into eleven stored round keys. This takes one cycle per round key. Then the core works through the rounds. One 32-bit substitution unit, made of four byte S-boxes, is shared by the key expansion and by the state. It substitutes one state column per cycle. A fifth cycle in each round applies the row shift, the column mixing and the round-key XOR to the whole state. Decryption uses the inverse transforms and takes the round keys from last to first.

State machine. The states are IDLE, KEXP (key expansion), INIT (initial key XOR), SUB (column substitution), MIX (row shift, column mix, key add) and DONE. The transitions are:
- IDLE to KEXP when start is seen.
- KEXP to itself until round key 10 has been written, then KEXP to INIT.
- INIT to SUB.
- SUB to itself for columns 0 to 2, then SUB to MIX after column 3.
- MIX to SUB after rounds 1 to 9, and MIX to DONE after round 10.
- DONE to IDLE.

Top module: `aes128_word_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `rd_data` reads 0 for every `rd_idx`.
- R2: Word index 0 of a load or a read is bits 127:96 of the block, which hold bytes 0 to 3 in column-major order. Index 3 is bits 31:0. Words may be written in any order.
- R3: With `decrypt`=0, the result is the AES-128 encryption of the block. The first step is an XOR with the cipher key. Rounds 1 to 9 then apply substitution, row shift, column mix and key add. Round 10 leaves out the column mix.
- R4: With `decrypt`=1, the result is the AES-128 decryption of the block. It applies the inverse transforms and uses the round keys in reverse order.
- R5: `decrypt` is sampled only in the cycle that `start` is accepted. Changing it while busy does not change the result.
- R6: `busy` rises in the cycle after an accepted start and stays high for exactly 62 cycles. `done` is then high for exactly one cycle, with `busy` low.
- R7: Buffer writes made while `busy` is high are ignored. They change neither the running result nor the buffers used by the next start.
- R8: A `start` pulse while `busy` is high is ignored and does not extend or restart the run.
- R9: The output buffer changes only in the cycle that `done` is high. Between runs, `rd_data` is stable for a fixed `rd_idx`.
- R10: Decrypting an encrypted block under the same key returns the original block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one word into a load buffer |
| wr_key | input | 1 | 1 selects the key buffer, 0 the data buffer |
| wr_idx | input | 2 | Word index of the write |
| wr_data | input | 32 | Word to write |
| start | input | 1 | Begin a run when idle |
| decrypt | input | 1 | Direction, sampled with start: 0 encrypt, 1 decrypt |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the result is available |
| rd_idx | input | 2 | Word index of the output buffer to read |
| rd_data | output | 32 | Selected word of the output buffer |

## Verification
Almost every fault inside the core shows up only at the end of a run, 63 cycles after start. A wrong round key, a wrong column counter or a wrong S-box byte spreads through the remaining rounds and corrupts all four result words, so the known-answer vectors in both directions catch it at the `done` cycle. A fault in the state sequencing shows up sooner, because the bench's per-cycle model of `busy` and `done` flags the first cycle where the 62-cycle window is shortened, stretched or restarted. Faults in the buffer gating show up in the run after a write made while busy, because a fresh start then reuses the load buffers without reloading them.

// File: rtl/aes128_pkg.sv
package aes128_pkg;
    localparam int WORD_W   = 32;
    localparam int BLK_W    = 128;
    localparam int N_WORDS  = BLK_W / WORD_W;
    localparam int N_ROUNDS = 10;
    localparam int IDX_W    = $clog2(N_WORDS);
    localparam int CNT_W    = $clog2(N_ROUNDS + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_KEXP, S_INIT, S_SUB, S_MIX, S_DONE
    } aes_st_e;

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] aa, r;
        aa = a;
        r  = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ aa;
            aa = xt(aa);
        end
        return r;
    endfunction

    // multiplicative inverse as a^254; zero maps to zero
    function automatic logic [7:0] ginv(input logic [7:0] a);
        logic [7:0] r, p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) r = gmul(r, p);
            p = gmul(p, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
        return (x << n) | (x >> (8 - n));
    endfunction

    function automatic logic [7:0] sbox_f(input logic [7:0] a);
        logic [7:0] b;
        b = ginv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] sbox_i(input logic [7:0] a);
        return ginv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
    endfunction

    function automatic logic [127:0] shift_rows(input logic [127:0] s, input logic inv);
        logic [127:0] o;
        int src;
        o = '0;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                src = inv ? ((c - r + 4) % 4) : ((c + r) % 4);
                o[127 - 8*(4*c + r) -: 8] = s[127 - 8*(4*src + r) -: 8];
            end
        end
        return o;
    endfunction

    function automatic logic [127:0] mix_cols(input logic [127:0] s, input logic inv);
        logic [127:0] o;
        logic [7:0] a [4];
        logic [7:0] k [4];
        logic [7:0] acc;
        o = '0;
        if (inv) begin
            k[0] = 8'h0e; k[1] = 8'h0b; k[2] = 8'h0d; k[3] = 8'h09;
        end else begin
            k[0] = 8'h02; k[1] = 8'h03; k[2] = 8'h01; k[3] = 8'h01;
        end
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) a[r] = s[127 - 8*(4*c + r) -: 8];
            for (int r = 0; r < 4; r++) begin
                acc = 8'h00;
                for (int j = 0; j < 4; j++) acc = acc ^ gmul(a[(r + j) % 4], k[j]);
                o[127 - 8*(4*c + r) -: 8] = acc;
            end
        end
        return o;
    endfunction
endpackage

// File: rtl/aes128_sbox_word.sv
module aes128_sbox_word
    import aes128_pkg::*;
(
    input  logic              inv,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int N_BYTES = WORD_W / 8;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_slice
        assign dout[8*g +: 8] = inv ? sbox_i(din[8*g +: 8]) : sbox_f(din[8*g +: 8]);
    end
endmodule

// File: rtl/aes128_key_next.sv
module aes128_key_next
    import aes128_pkg::*;
(
    input  logic [BLK_W-1:0]  prev,
    input  logic [WORD_W-1:0] sub_w,
    input  logic [7:0]        rcon,
    output logic [WORD_W-1:0] rot_w,
    output logic [BLK_W-1:0]  next
);
    logic [WORD_W-1:0] w [N_WORDS];

    assign rot_w = {prev[23:0], prev[31:24]};

    always_comb begin
        w[0] = prev[BLK_W-1 -: WORD_W] ^ sub_w ^ {rcon, 24'h0};
        for (int i = 1; i < N_WORDS; i++)
            w[i] = prev[BLK_W-1-WORD_W*i -: WORD_W] ^ w[i-1];
        for (int i = 0; i < N_WORDS; i++)
            next[BLK_W-1-WORD_W*i -: WORD_W] = w[i];
    end
endmodule

// File: rtl/aes128_round_mix.sv
module aes128_round_mix
    import aes128_pkg::*;
(
    input  logic [BLK_W-1:0] s,
    input  logic [BLK_W-1:0] rk,
    input  logic             inv,
    input  logic             last,
    output logic [BLK_W-1:0] o
);
    logic [BLK_W-1:0] sh;

    always_comb begin
        sh = shift_rows(s, inv);
        if (!inv) o = (last ? sh : mix_cols(sh, 1'b0)) ^ rk;
        else      o = last ? (sh ^ rk) : mix_cols(sh ^ rk, 1'b1);
    end
endmodule

// File: rtl/aes128_word_core.sv
module aes128_word_core
    import aes128_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_key,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start,
    input  logic              decrypt,
    output logic              busy,
    output logic              done,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    aes_st_e           st, st_nx;
    logic [BLK_W-1:0]  blk_buf, key_buf, state, res;
    logic [BLK_W-1:0]  rk [N_ROUNDS+1];
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  col;
    logic [7:0]        rcon;
    logic              dec_q, done_q;

    logic [CNT_W-1:0]  prv_idx, key_idx;
    logic [6:0]        col_base, wr_base, rd_base;
    logic [WORD_W-1:0] rot_w, sub_in, sub_out;
    logic [BLK_W-1:0]  key_nx, mix_out;
    logic              last_rnd;

    assign prv_idx  = cnt - CNT_W'(1);
    assign key_idx  = dec_q ? (CNT_W'(N_ROUNDS) - cnt) : cnt;
    assign last_rnd = (cnt == CNT_W'(N_ROUNDS));
    assign col_base = 7'd127 - {col, 5'b0};
    assign wr_base  = 7'd127 - {wr_idx, 5'b0};
    assign rd_base  = 7'd127 - {rd_idx, 5'b0};
    assign sub_in   = (st == S_KEXP) ? rot_w : state[col_base -: WORD_W];

    aes128_sbox_word u_sbox (
        .inv  (dec_q && (st == S_SUB)),
        .din  (sub_in),
        .dout (sub_out)
    );

    aes128_key_next u_key (
        .prev  (rk[prv_idx]),
        .sub_w (sub_out),
        .rcon  (rcon),
        .rot_w (rot_w),
        .next  (key_nx)
    );

    aes128_round_mix u_mix (
        .s    (state),
        .rk   (rk[key_idx]),
        .inv  (dec_q),
        .last (last_rnd),
        .o    (mix_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (start) st_nx = S_KEXP;
            S_KEXP: if (last_rnd) st_nx = S_INIT;
            S_INIT: st_nx = S_SUB;
            S_SUB:  if (col == IDX_W'(N_WORDS - 1)) st_nx = S_MIX;
            S_MIX:  st_nx = last_rnd ? S_DONE : S_SUB;
            S_DONE: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_buf <= '0;
            key_buf <= '0;
            state   <= '0;
            res     <= '0;
            cnt     <= '0;
            col     <= '0;
            rcon    <= 8'h01;
            dec_q   <= 1'b0;
            done_q  <= 1'b0;
            for (int i = 0; i <= N_ROUNDS; i++) rk[i] <= '0;
        end else begin
            done_q <= (st == S_DONE);
            unique case (st)
                S_IDLE: begin
                    if (wr_en && wr_key)  key_buf[wr_base -: WORD_W] <= wr_data;
                    if (wr_en && !wr_key) blk_buf[wr_base -: WORD_W] <= wr_data;
                    if (start) begin
                        dec_q <= decrypt;
                        rk[0] <= key_buf;
                        cnt   <= CNT_W'(1);
                        rcon  <= 8'h01;
                    end
                end
                S_KEXP: begin
                    rk[cnt] <= key_nx;
                    rcon    <= xt(rcon);
                    if (!last_rnd) cnt <= cnt + CNT_W'(1);
                end
                S_INIT: begin
                    state <= blk_buf ^ (dec_q ? rk[N_ROUNDS] : rk[0]);
                    cnt   <= CNT_W'(1);
                    col   <= '0;
                end
                S_SUB: begin
                    state[col_base -: WORD_W] <= sub_out;
                    col <= col + IDX_W'(1);
                end
                S_MIX: begin
                    state <= mix_out;
                    cnt   <= cnt + CNT_W'(1);
                    col   <= '0;
                end
                S_DONE: res <= state;
                default: ;
            endcase
        end
    end

    assign busy    = (st != S_IDLE);
    assign done    = done_q;
    assign rd_data = res[rd_base -: WORD_W];
endmodule

// File: rtl/aes128_word_core_chk.sv
module aes128_word_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [1:0]  rd_idx,
    input logic [31:0] rd_data
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                          // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                          // R6
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                               // R6
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                    // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_idx) && !done) |-> $stable(rd_data));         // R9
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !done || !busy);                      // R8
endmodule

bind aes128_word_core aes128_word_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
);

// File: tb/aes128_word_core_tb.sv
`timescale 1ns/1ps
module aes128_word_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_key = 1'b0, start = 1'b0, decrypt = 1'b0;
    logic [1:0]  wr_idx = '0, rd_idx = '0;
    logic [31:0] wr_data = '0;
    logic        busy, done;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;

    always #2.5 clk = ~clk;

    aes128_word_core u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_key),
        .wr_idx(wr_idx), .wr_data(wr_data), .start(start), .decrypt(decrypt),
        .busy(busy), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // behavioural timing model: 62 busy cycles, then one done cycle
    int   m_cnt = 0;
    logic m_done = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  = 0;
            m_done = 1'b0;
        end else begin
            m_done = (m_cnt == 1);
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            else if (start) m_cnt = 62;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (busy !== (m_cnt > 0) || done !== m_done) begin
                n_fail++;
                $display("FAIL R6/R8 busy/done act=%b/%b exp=%b/%b at %0t",
                         busy, done, (m_cnt > 0), m_done, $time);
            end
        end
    end

    task automatic chk(input logic ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic key, input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_key = key; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic key, input logic [127:0] v);
        for (int i = 0; i < 4; i++) put(key, 2'(i), v[127 - 32*i -: 32]);
    endtask

    task automatic kick(input logic dec);
        @(negedge clk);
        start = 1'b1; decrypt = dec;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
    endtask

    task automatic read_all(output logic [127:0] v);
        for (int i = 0; i < 4; i++) begin
            rd_idx = 2'(i);
            #1;
            v[127 - 32*i -: 32] = rd_data;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [127:0] r, r2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        read_all(r);
        chk(r == '0 && !busy && !done, "R1", r, '0);

        // R2 load order (indices written out of order), R3 encryption
        put(1'b1, 2'd3, K1[31:0]);  put(1'b1, 2'd1, K1[95:64]);
        put(1'b1, 2'd0, K1[127:96]); put(1'b1, 2'd2, K1[63:32]);
        load(1'b0, P1);
        kick(1'b0);
        wait_done();
        read_all(r);
        chk(r == C1, "R2 R3 encrypt vector 1", r, C1);
        chk(r[127:96] == 32'h69c4e0d8, "R2 word 0 is MS", {96'h0, r[127:96]}, {96'h0, 32'h69c4e0d8});

        // R4 decryption
        load(1'b0, C1);
        kick(1'b1);
        wait_done();
        read_all(r);
        chk(r == P1, "R4 decrypt vector 1", r, P1);

        // R3 / R4 second vector
        load(1'b1, K2);
        load(1'b0, P2);
        kick(1'b0);
        wait_done();
        read_all(r);
        chk(r == C2, "R3 encrypt vector 2", r, C2);
        load(1'b0, C2);
        kick(1'b1);
        wait_done();
        read_all(r);
        chk(r == P2, "R4 decrypt vector 2", r, P2);

        // R5 mode flipped while busy; R7 writes while busy; R8 start while busy
        load(1'b0, P2);
        kick(1'b0);
        decrypt = 1'b1;
        put(1'b0, 2'd0, 32'hdeadbeef);
        put(1'b1, 2'd2, 32'h12345678);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        read_all(r);
        chk(r == C2, "R5 R7 R8 result unaffected by busy inputs", r, C2);
        // R7 buffers untouched: restart without reloading
        kick(1'b0);
        wait_done();
        read_all(r);
        chk(r == C2, "R7 load buffers unchanged", r, C2);

        // R9 hold between runs
        repeat (20) @(negedge clk);
        read_all(r2);
        chk(r2 == r, "R9 output held", r2, r);

        // R10 round trip with an arbitrary block
        load(1'b0, 128'hfedcba9876543210_0f1e2d3c4b5a6978);
        kick(1'b0);
        wait_done();
        read_all(r);
        chk(r != 128'hfedcba9876543210_0f1e2d3c4b5a6978, "R10 ciphertext differs", r, 128'h0);
        load(1'b0, r);
        kick(1'b1);
        wait_done();
        read_all(r2);
        chk(r2 == 128'hfedcba9876543210_0f1e2d3c4b5a6978, "R10 round trip", r2,
            128'hfedcba9876543210_0f1e2d3c4b5a6978);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule